// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry-Out

This unit sits in a processor execute stage. It takes a data word, a shift length and an operation code. It returns the shifted or rotated word together with the carry flag value that the stage should write back. Four operations are supported: arithmetic right shift, logical right shift, logical left shift and rotate right.

Each operation has its own carry-out rule. A zero shift length leaves the word untouched and passes the incoming carry through. Lengths at the word width and beyond saturate in a way that depends on the operation. When flag update is off, the incoming carry is returned whatever the length.

The word width and the shift-length width are parameters. The defaults are a 32-bit word and an 8-bit length, so every length from 0 to 255 has a defined result. The result and the carry are registered: the values presented at one clock edge appear on the outputs after that edge.

Top module: `barrel_carry_unit`

## Requirements
- R1: A shift length of 0 gives a result equal to the operand, and a carry equal to the incoming carry, for every operation code.
- R2: Operation code 0 is arithmetic right shift. For a length n with 1 ≤ n ≤ 31, the top n result bits copy operand bit 31, and the carry is operand bit n-1.
- R3: Arithmetic right shift with n ≥ 32 sets every result bit and the carry to operand bit 31.
- R4: Operation code 1 is logical right shift. For 1 ≤ n ≤ 31, the top n result bits are zero, and the carry is operand bit n-1.
- R5: Operation code 2 is logical left shift. For 1 ≤ n ≤ 31, the low n result bits are zero, and the carry is operand bit 32-n.
- R6: A logical shift by exactly 32 gives an all-zero result. The carry is operand bit 31 for a right shift and operand bit 0 for a left shift.
- R7: A logical shift by 33 or more gives an all-zero result and a carry of 0.
- R8: Operation code 3 is rotate right. For 1 ≤ n ≤ 31, the low n operand bits move to the top n result bits, and the carry is operand bit n-1.
- R9: A rotate by n ≥ 32 behaves as a rotate by n mod 32. A nonzero multiple of 32 returns the operand unchanged, with carry equal to operand bit 31.
- R10: When flag update is low, the carry output equals the incoming carry for every length and operation, and the result is unaffected.
- R11: Outputs register the function of the inputs sampled at the previous rising clock edge. A synchronous active-high reset clears the result and the carry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand_in | input | 32 | Word to shift or rotate |
| shamt_in | input | 8 | Shift length |
| op_sel | input | 2 | 0 arithmetic right, 1 logical right, 2 logical left, 3 rotate right |
| carry_in | input | 1 | Current carry flag |
| flag_upd_in | input | 1 | Enables carry update |
| result_q | output | 32 | Registered result |
| carry_q | output | 1 | Registered carry to write back |

## Verification
Two rules can apply in the same cycle. The zero-length pass-through or the flag-update disable can coincide with the saturation rule for lengths of 32 and above. In those cycles the carry must come from the pass-through, while the result follows the saturation rule. The bench sweeps every length from 0 to 255 for every operation and several operand patterns, with flag update both high and low, so that every such overlap occurs. It judges result and carry separately against values computed arithmetically from the requirements.

// File: rtl/barrel_carry_pkg.sv
package barrel_carry_pkg;
  typedef enum logic [1:0] {
    OP_ASR = 2'd0,
    OP_LSR = 2'd1,
    OP_LSL = 2'd2,
    OP_ROR = 2'd3
  } shift_op_e;
endpackage

// File: rtl/bit_mirror.sv
module bit_mirror #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/rotr_stages.sv
module rotr_stages #(
  parameter int W    = 32,
  parameter int LOGW = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [LOGW-1:0] amt,
  output logic [W-1:0]    dout
);
  logic [W-1:0] stage [LOGW+1];

  assign stage[0] = din;

  for (genvar s = 0; s < LOGW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {stage[s][STEP-1:0], stage[s][W-1:STEP]} : stage[s];
  end

  assign dout = stage[LOGW];
endmodule

// File: rtl/keep_mask.sv
module keep_mask #(
  parameter int W    = 32,
  parameter int LOGW = $clog2(W)
) (
  input  logic [LOGW-1:0] amt,
  output logic [W-1:0]    keep
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign keep[i] = (i + int'(amt)) < W;
  end
endmodule

// File: rtl/barrel_carry_unit.sv
module barrel_carry_unit #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     operand_in,
  input  logic [AMT_W-1:0] shamt_in,
  input  logic [1:0]       op_sel,
  input  logic             carry_in,
  input  logic             flag_upd_in,
  output logic [W-1:0]     result_q,
  output logic             carry_q
);
  import barrel_carry_pkg::*;

  localparam int LOGW = $clog2(W);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

  shift_op_e    op;
  logic         len_zero, len_big, len_exact, is_left, sign_bit;
  logic [LOGW-1:0] rot_amt;
  logic [W-1:0] core_in, rot_out, keep, filled, left_out, res_d;
  logic         carry_d;

  assign op        = shift_op_e'(op_sel);
  assign len_zero  = (shamt_in == '0);
  assign len_big   = (shamt_in >= W_AMT);
  assign len_exact = (shamt_in == W_AMT);
  assign rot_amt   = shamt_in[LOGW-1:0];
  assign is_left   = (op == OP_LSL);
  assign sign_bit  = operand_in[W-1];

  logic [W-1:0] mirrored_in;

  bit_mirror #(.W(W)) u_mirror_in (
    .din  (operand_in),
    .dout (mirrored_in)
  );

  assign core_in = is_left ? mirrored_in : operand_in;

  rotr_stages #(.W(W), .LOGW(LOGW)) u_rot (
    .din  (core_in),
    .amt  (rot_amt),
    .dout (rot_out)
  );

  keep_mask #(.W(W), .LOGW(LOGW)) u_mask (
    .amt  (rot_amt),
    .keep (keep)
  );

  always_comb begin
    filled = rot_out & keep;
    if (op == OP_ASR && sign_bit) begin
      filled = filled | ~keep;
    end
  end

  bit_mirror #(.W(W)) u_mirror_out (
    .din  (filled),
    .dout (left_out)
  );

  always_comb begin
    res_d = operand_in;
    if (!len_zero) begin
      unique case (op)
        OP_ASR:  res_d = len_big ? {W{sign_bit}} : filled;
        OP_LSR:  res_d = len_big ? '0 : filled;
        OP_LSL:  res_d = len_big ? '0 : left_out;
        default: res_d = rot_out;
      endcase
    end
  end

  always_comb begin
    carry_d = carry_in;
    if (flag_upd_in && !len_zero) begin
      if (len_big && !len_exact) begin
        unique case (op)
          OP_ASR:  carry_d = sign_bit;
          OP_LSR:  carry_d = 1'b0;
          OP_LSL:  carry_d = 1'b0;
          default: carry_d = rot_out[W-1];
        endcase
      end else begin
        carry_d = rot_out[W-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      carry_q  <= 1'b0;
    end else begin
      result_q <= res_d;
      carry_q  <= carry_d;
    end
  end
endmodule

// File: rtl/barrel_carry_checker.sv
module barrel_carry_checker #(
  parameter int W     = 32,
  parameter int AMT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     operand_in,
  input logic [AMT_W-1:0] shamt_in,
  input logic [1:0]       op_sel,
  input logic             carry_in,
  input logic             flag_upd_in,
  input logic [W-1:0]     result_q,
  input logic             carry_q
);
  logic primed = 1'b0;

  always_ff @(posedge clk) primed <= !rst;

  assert_zero_len_R1: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(shamt_in) == '0) |->
      (result_q == $past(operand_in) && carry_q == $past(carry_in)));

  assert_asr_sat_R3: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op_sel) == 2'd0 && int'($past(shamt_in)) >= W) |->
      (result_q == {W{$past(operand_in[W-1])}}));

  assert_logic_far_R7: assert property (@(posedge clk) disable iff (rst)
    (primed && ($past(op_sel) == 2'd1 || $past(op_sel) == 2'd2) &&
     int'($past(shamt_in)) > W && $past(flag_upd_in)) |->
      (result_q == '0 && !carry_q));

  assert_rot_ones_R8: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op_sel) == 2'd3) |->
      ($countones(result_q) == $countones($past(operand_in))));

  assert_hold_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (primed && !$past(flag_upd_in)) |-> (carry_q == $past(carry_in)));
endmodule

bind barrel_carry_unit barrel_carry_checker #(.W(W), .AMT_W(AMT_W)) u_checker (
  .clk         (clk),
  .rst         (rst),
  .operand_in  (operand_in),
  .shamt_in    (shamt_in),
  .op_sel      (op_sel),
  .carry_in    (carry_in),
  .flag_upd_in (flag_upd_in),
  .result_q    (result_q),
  .carry_q     (carry_q)
);

// File: tb/barrel_carry_unit_bench.sv
module barrel_carry_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand_in = '0;
  logic [7:0]  shamt_in = '0;
  logic [1:0]  op_sel = '0;
  logic        carry_in = 1'b0;
  logic        flag_upd_in = 1'b0;
  logic [31:0] result_q;
  logic        carry_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  barrel_carry_unit u_barrel_carry_unit (
    .clk         (clk),
    .rst         (rst),
    .operand_in  (operand_in),
    .shamt_in    (shamt_in),
    .op_sel      (op_sel),
    .carry_in    (carry_in),
    .flag_upd_in (flag_upd_in),
    .result_q    (result_q),
    .carry_q     (carry_q)
  );

  function automatic logic [31:0] exp_result(logic [31:0] v, int n, int op);
    int k;
    if (n == 0) return v;
    case (op)
      0: return (n >= 32) ? {32{v[31]}} : 32'($signed(v) >>> n);
      1: return (n >= 32) ? 32'd0 : v >> n;
      2: return (n >= 32) ? 32'd0 : v << n;
      default: begin
        k = n % 32;
        if (k == 0) return v;
        return (v >> k) | (v << (32 - k));
      end
    endcase
  endfunction

  function automatic logic exp_carry(logic [31:0] v, int n, int op, logic cin, logic upd);
    int k;
    if (!upd || n == 0) return cin;
    case (op)
      0: return (n >= 32) ? v[31] : v[n-1];
      1: return (n > 32) ? 1'b0 : v[n-1];
      2: return (n > 32) ? 1'b0 : v[32-n];
      default: begin
        k = n % 32;
        return (k == 0) ? v[31] : v[k-1];
      end
    endcase
  endfunction

  function automatic string res_tag(int n, int op);
    if (n == 0) return "R1";
    case (op)
      0: return (n < 32) ? "R2" : "R3";
      1: return (n < 32) ? "R4" : (n == 32 ? "R6" : "R7");
      2: return (n < 32) ? "R5" : (n == 32 ? "R6" : "R7");
      default: return (n < 32) ? "R8" : "R9";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  logic [31:0] pats [8] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5A5_3C3C, 32'h0000_0000,
                            32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h1234_5678};

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "reset result", result_q, 32'd0);
    check("R11", "reset carry", {31'd0, carry_q}, 32'd0);
    operand_in = 32'hDEAD_BEEF;
    shamt_in = 8'd4;
    op_sel = 2'd3;
    @(negedge clk);
    check("R11", "result held in reset", result_q, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", "first registered result", result_q, 32'hFDEA_DBEE);
    for (int p = 0; p < 8; p++) begin
      for (int op = 0; op < 4; op++) begin
        for (int m = 0; m < 4; m++) begin
          for (int n = 0; n < 256; n++) begin
            logic ci, up;
            ci = m[0];
            up = m[1];
            operand_in = pats[p];
            shamt_in = 8'(n);
            op_sel = 2'(op);
            carry_in = ci;
            flag_upd_in = up;
            @(negedge clk);
            check(res_tag(n, op), $sformatf("result op=%0d n=%0d", op, n),
                  result_q, exp_result(pats[p], n, op));
            check(!up ? "R10" : res_tag(n, op), $sformatf("carry op=%0d n=%0d", op, n),
                  {31'd0, carry_q}, {31'd0, exp_carry(pats[p], n, op, ci, up)});
          end
        end
      end
    end
    rst = 1'b1;
    @(negedge clk);
    check("R11", "reset clears result", result_q, 32'd0);
    finish_run();
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule